// File: doc/BRIEF.md
# Scan Mode Command Sequencer

This block sits behind the serial port of a multi-channel sampling converter. At the end of every frame it reads the 16-bit command word captured during that frame. It then updates the operating mode and picks the channel that the next frame will convert. Nothing changes between frame ends, so the converter can use the channel index and mode as stable controls for the whole of the following frame.

There are five named states: `MODE_RST` (the state after reset and after a reset command), `MODE_STBY`, `MODE_PWDN`, `MODE_AUTO` and `MODE_MAN`. A transition happens only on the frame-end strobe, and the command selects it:
- reset, standby and power-down commands go to the matching parked state;
- the automatic command goes to `MODE_AUTO` and restarts the scan;
- a manual or auxiliary command goes to `MODE_MAN`;
- a no-op keeps the state. In `MODE_AUTO` a no-op steps the scan; in `MODE_MAN` it repeats the same channel.

A channel is eligible for the automatic scan when its sequence-enable bit is 1 and its front-end power-down bit is 0. The last executed command is kept for read-back.

Top module: `scan_cmd_seq`

## Requirements
- R1: After reset, `mode` is 0 (reset mode), `next_ch` is 0, `no_chan` is 0 and `cmd_rb` is 0000h. The mode codes are 0 reset, 1 standby, 2 power-down, 3 automatic and 4 manual.
- R2: Outputs change only on the clock edge where `frame_end` is 1. A changing `cmd_word` with `frame_end` low leaves every output unchanged.
- R3: At a frame end, 8200h selects standby (1), 8300h selects power-down (2) and 8500h selects reset mode (0). `next_ch` holds its value.
- R4: In standby, power-down or reset mode, a frame with 0000h or any unrecognized word keeps the mode unchanged. Only an automatic, manual or auxiliary command leaves these modes.
- R5: A word C000h + n×0400h with n below NUM_CH selects manual mode (4) with `next_ch` = n. Following no-op frames keep the same channel.
- R6: E000h selects manual mode with `next_ch` = NUM_CH, which is the auxiliary input.
- R7: A000h selects automatic mode (3) with `next_ch` set to the lowest eligible channel. A channel is eligible when its `seq_en` bit is 1 and its `ch_pd` bit is 0.
- R8: In automatic mode a no-op frame moves `next_ch` to the lowest eligible channel above the current one. If there is none above, it wraps to the lowest eligible channel.
- R9: A000h received during an automatic scan restarts it at the lowest eligible channel, whatever the current position.
- R10: When automatic mode is entered or continued with no eligible channel, `no_chan` becomes 1 and `next_ch` holds. `no_chan` is 0 after any other frame end.
- R11: `cmd_rb` shows the recognized command word of the frame that last ended. A no-op or unrecognized word reads back as 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end | input | 1 | One-cycle strobe marking the end of a frame |
| cmd_word | input | 16 | Command word captured in the current frame |
| seq_en | input | NUM_CH | Per-channel automatic sequence enable |
| ch_pd | input | NUM_CH | Per-channel front-end power-down |
| mode | output | 3 | Current operating mode code |
| next_ch | output | $clog2(NUM_CH+1) | Channel to convert in the next frame |
| no_chan | output | 1 | Automatic mode has no eligible channel |
| cmd_rb | output | 16 | Last executed command word |

## Verification
The hardest case to reach is the wrap of the automatic scan while the eligible set changes between frames. The current channel may itself have just become ineligible, or the set may have become empty and then filled again.

The directed part sets up a sparse mask, walks it past the highest channel, and then empties it and refills it. The random part draws both masks afresh on most frames and mostly issues no-ops while in automatic mode, so these wraps and drop-outs occur many times.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        MODE_RST  = 3'd0,
        MODE_STBY = 3'd1,
        MODE_PWDN = 3'd2,
        MODE_AUTO = 3'd3,
        MODE_MAN  = 3'd4
    } scan_mode_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_STBY,
        OP_PWDN,
        OP_RST,
        OP_AUTO,
        OP_MAN,
        OP_AUX
    } scan_op_e;

    localparam logic [15:0] CW_STBY = 16'h8200;
    localparam logic [15:0] CW_PWDN = 16'h8300;
    localparam logic [15:0] CW_RST  = 16'h8500;
    localparam logic [15:0] CW_AUTO = 16'hA000;
    localparam logic [15:0] CW_AUX  = 16'hE000;
    localparam logic [2:0]  CW_MAN_TAG = 3'b110;

endpackage

// File: rtl/scan_cmd_decode.sv
module scan_cmd_decode
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W = $clog2(NUM_CH + 1)
) (
    input  logic [15:0]     cmd,
    output scan_op_e        op,
    output logic [CH_W-1:0] man_ch
);

    logic man_hit;

    // Manual words: tag in the top three bits, channel in bits 12:10, rest zero
    assign man_hit = (cmd[15:13] == CW_MAN_TAG) && (cmd[9:0] == 10'd0)
                   && (int'(cmd[12:10]) < NUM_CH);
    assign man_ch  = CH_W'(cmd[12:10]);

    always_comb begin
        if (cmd == CW_STBY)      op = OP_STBY;
        else if (cmd == CW_PWDN) op = OP_PWDN;
        else if (cmd == CW_RST)  op = OP_RST;
        else if (cmd == CW_AUTO) op = OP_AUTO;
        else if (cmd == CW_AUX)  op = OP_AUX;
        else if (man_hit)        op = OP_MAN;
        else                     op = OP_NOP;
    end

endmodule

// File: rtl/scan_ch_pick.sv
module scan_ch_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W = $clog2(NUM_CH + 1)
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic [CH_W-1:0]   cur,
    output logic              any,
    output logic [CH_W-1:0]   lowest,
    output logic [CH_W-1:0]   after
);

    logic            above_hit;
    logic [CH_W-1:0] above_idx;

    assign any = |elig;

    // Downward loops leave the smallest matching index as the final winner
    always_comb begin
        lowest = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig[i]) lowest = CH_W'(i);
        end
    end

    always_comb begin
        above_hit = 1'b0;
        above_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig[i] && (CH_W'(i) > cur)) begin
                above_hit = 1'b1;
                above_idx = CH_W'(i);
            end
        end
    end

    assign after = above_hit ? above_idx : lowest;

endmodule

// File: rtl/scan_cmd_seq.sv
module scan_cmd_seq
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [15:0]       cmd_word,
    input  logic [NUM_CH-1:0] seq_en,
    input  logic [NUM_CH-1:0] ch_pd,
    output logic [2:0]        mode,
    output logic [CH_W-1:0]   next_ch,
    output logic              no_chan,
    output logic [15:0]       cmd_rb
);

    localparam logic [CH_W-1:0] AUX_IDX = CH_W'(NUM_CH);

    scan_mode_e      state_q, state_d;
    scan_op_e        op;
    logic [CH_W-1:0] man_ch;
    logic [NUM_CH-1:0] elig;
    logic            any_elig;
    logic [CH_W-1:0] low_ch, step_ch;
    logic [CH_W-1:0] ch_d;
    logic            nc_d;
    logic [15:0]     rb_d;

    assign elig = seq_en & ~ch_pd;

    scan_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .cmd    (cmd_word),
        .op     (op),
        .man_ch (man_ch)
    );

    scan_ch_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig   (elig),
        .cur    (next_ch),
        .any    (any_elig),
        .lowest (low_ch),
        .after  (step_ch)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_NOP:  state_d = state_q;
            OP_STBY: state_d = MODE_STBY;
            OP_PWDN: state_d = MODE_PWDN;
            OP_RST:  state_d = MODE_RST;
            OP_AUTO: state_d = MODE_AUTO;
            OP_MAN,
            OP_AUX:  state_d = MODE_MAN;
            default: state_d = state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state_q <= MODE_RST;
        else if (frame_end) state_q <= state_d;
    end

    // Output selection
    always_comb begin
        ch_d = next_ch;
        nc_d = 1'b0;
        rb_d = (op == OP_NOP) ? 16'h0000 : cmd_word;
        unique case (op)
            OP_NOP: begin
                if (state_q == MODE_AUTO) begin
                    if (any_elig) ch_d = step_ch;
                    else          nc_d = 1'b1;
                end
            end
            OP_AUTO: begin
                if (any_elig) ch_d = low_ch;
                else          nc_d = 1'b1;
            end
            OP_MAN:  ch_d = man_ch;
            OP_AUX:  ch_d = AUX_IDX;
            default: ch_d = next_ch;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_ch <= '0;
            no_chan <= 1'b0;
            cmd_rb  <= 16'h0000;
        end else if (frame_end) begin
            next_ch <= ch_d;
            no_chan <= nc_d;
            cmd_rb  <= rb_d;
        end
    end

    assign mode = state_q;

endmodule

// File: rtl/scan_cmd_seq_chk.sv
module scan_cmd_seq_chk #(
    parameter int NUM_CH = 8,
    parameter int CH_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic [15:0]       cmd_word,
    input logic [NUM_CH-1:0] seq_en,
    input logic [NUM_CH-1:0] ch_pd,
    input logic [2:0]        mode,
    input logic [CH_W-1:0]   next_ch,
    input logic              no_chan,
    input logic [15:0]       cmd_rb
);

    a_r2_quiet_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(mode) && $stable(next_ch) && $stable(no_chan) && $stable(cmd_rb)));

    a_r3_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cmd_word == 16'h8200) |=> (mode == 3'd1 && $stable(next_ch)));

    a_r4_parked_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cmd_word == 16'h0000 && (mode == 3'd0 || mode == 3'd1 || mode == 3'd2))
        |=> $stable(mode));

    a_r5_manual_one: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cmd_word == 16'hC400) |=> (mode == 3'd4 && next_ch == CH_W'(1)));

    a_r6_aux_select: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cmd_word == 16'hE000) |=> (mode == 3'd4 && next_ch == CH_W'(NUM_CH)));

    a_r7_auto_found: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cmd_word == 16'hA000 && |(seq_en & ~ch_pd)) |=> (mode == 3'd3 && !no_chan));

    a_r10_flag_only_auto: assert property (@(posedge clk) disable iff (!rst_n)
        no_chan |-> mode == 3'd3);

    a_r11_readback_pwdn: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cmd_word == 16'h8300) |=> cmd_rb == 16'h8300);

endmodule

bind scan_cmd_seq scan_cmd_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .cmd_word  (cmd_word),
    .seq_en    (seq_en),
    .ch_pd     (ch_pd),
    .mode      (mode),
    .next_ch   (next_ch),
    .no_chan   (no_chan),
    .cmd_rb    (cmd_rb)
);

// File: tb/sim_scan_cmd_seq.sv
module sim_scan_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int CW = $clog2(NCH + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_end = 1'b0;
    logic [15:0]    cmd_word = 16'h0000;
    logic [NCH-1:0] seq_en = '1;
    logic [NCH-1:0] ch_pd = '0;
    logic [2:0]     mode;
    logic [CW-1:0]  next_ch;
    logic           no_chan;
    logic [15:0]    cmd_rb;

    int n_chk = 0;
    int n_bad = 0;

    // Expected state, derived from the requirements
    int          m_mode = 0;
    int          m_ch = 0;
    logic        m_nc = 1'b0;
    logic [15:0] m_rb = 16'h0000;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_cmd_seq #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cmd_word(cmd_word),
        .seq_en(seq_en), .ch_pd(ch_pd), .mode(mode), .next_ch(next_ch),
        .no_chan(no_chan), .cmd_rb(cmd_rb)
    );

    // Returns the channel of a valid manual word, NCH for the auxiliary word, -1 otherwise
    function automatic int man_target(input logic [15:0] w);
        if (w == 16'hE000) return NCH;
        if (w[15:13] == 3'b110 && w[9:0] == 0 && int'(w[12:10]) < NCH) return int'(w[12:10]);
        return -1;
    endfunction

    function automatic bit known(input logic [15:0] w);
        return (w == 16'h8200 || w == 16'h8300 || w == 16'h8500 || w == 16'hA000
                || man_target(w) >= 0);
    endfunction

    function automatic int lowest_of(input logic [NCH-1:0] e);
        for (int i = 0; i < NCH; i++) if (e[i]) return i;
        return -1;
    endfunction

    function automatic int step_of(input logic [NCH-1:0] e, input int cur);
        for (int i = 0; i < NCH; i++) if (e[i] && i > cur) return i;
        return lowest_of(e);
    endfunction

    task automatic model(input logic [15:0] w, input logic [NCH-1:0] en, input logic [NCH-1:0] pd);
        logic [NCH-1:0] e = en & ~pd;
        m_nc = 1'b0;
        m_rb = known(w) ? w : 16'h0000;
        if (w == 16'h8200)      m_mode = 1;
        else if (w == 16'h8300) m_mode = 2;
        else if (w == 16'h8500) m_mode = 0;
        else if (w == 16'hA000) begin
            m_mode = 3;
            if (e != 0) m_ch = lowest_of(e); else m_nc = 1'b1;
        end else if (man_target(w) >= 0) begin
            m_mode = 4;
            m_ch = man_target(w);
        end else if (m_mode == 3) begin
            if (e != 0) m_ch = step_of(e, m_ch); else m_nc = 1'b1;
        end
    endtask

    task automatic check(input string req);
        n_chk++;
        if (int'(mode) != m_mode || int'(next_ch) != m_ch || no_chan != m_nc || cmd_rb != m_rb) begin
            n_bad++;
            $display("FAIL %s: got mode=%0d ch=%0d nc=%0b rb=%h, want mode=%0d ch=%0d nc=%0b rb=%h",
                     req, mode, next_ch, no_chan, cmd_rb, m_mode, m_ch, m_nc, m_rb);
        end
    endtask

    task automatic frame(input logic [15:0] w, input logic [NCH-1:0] en,
                         input logic [NCH-1:0] pd, input string req);
        @(negedge clk);
        cmd_word = w; seq_en = en; ch_pd = pd; frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        model(w, en, pd);
        check(req);
    endtask

    // R2: words moving with no strobe must leave all outputs alone
    task automatic idle_noise(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            cmd_word = (k[0]) ? 16'hA000 : 16'h8300;
            seq_en = NCH'($urandom);
        end
        @(negedge clk);
        check("R2");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        int sel;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        idle_noise(4);

        // R4 parked in reset mode; R3 park transitions
        frame(16'h0000, '1, '0, "R4");
        frame(16'h1234, '1, '0, "R4 R11");
        frame(16'h8200, '1, '0, "R3 R11");
        frame(16'h0000, '1, '0, "R4 R11");
        frame(16'hC001, '1, '0, "R4");
        frame(16'h8300, '1, '0, "R3 R11");
        frame(16'h8500, '1, '0, "R3");
        // R7 eligible set {1,5,7}; R8 ascending with wrap; R9 restart
        frame(16'hA000, 8'b1010_0110, 8'b0000_0100, "R7");
        frame(16'h0000, 8'b1010_0110, 8'b0000_0100, "R8");
        frame(16'h0000, 8'b1010_0110, 8'b0000_0100, "R8");
        frame(16'h0000, 8'b1010_0110, 8'b0000_0100, "R8 wrap");
        frame(16'h0000, 8'b1010_0110, 8'b0000_0100, "R8");
        frame(16'hA000, 8'b1010_0110, 8'b0000_0100, "R9");
        // current channel drops out of the set
        frame(16'h0000, 8'b1000_0100, 8'b0000_0000, "R8");
        // R10 empty set, then refill
        frame(16'h0000, 8'b0000_0000, 8'b0000_0000, "R10");
        frame(16'hA000, 8'b1111_0000, 8'b1111_0000, "R10");
        frame(16'h0000, 8'b0000_1001, 8'b0000_0000, "R8 R10");
        // R5 manual and repeat; R6 auxiliary
        frame(16'hC800, '1, '0, "R5");
        frame(16'h0000, '1, '0, "R5");
        frame(16'hDC00, '1, '0, "R5");
        frame(16'hE000, '1, '0, "R6");
        frame(16'h0000, '1, '0, "R6");
        frame(16'h8200, '1, '0, "R3");
        frame(16'hA000, 8'h01, '0, "R7");
        idle_noise(3);

        for (int i = 0; i < 400; i++) begin
            sel = int'($urandom_range(0, 15));
            case (sel)
                0:       w = 16'h8200;
                1:       w = 16'h8300;
                2:       w = 16'h8500;
                3, 4:    w = 16'hA000;
                5:       w = 16'hE000;
                6, 7:    w = 16'hC000 | (16'($urandom_range(0, 7)) << 10);
                8:       w = 16'($urandom);
                default: w = 16'h0000;
            endcase
            frame(w, NCH'($urandom), NCH'($urandom) & NCH'($urandom), "R8 random");
            if (i % 50 == 0) idle_noise(2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule